// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter Chain

This block holds wall-clock time and calendar date as packed BCD registers: seconds, minutes, hours, day of week, day of month, month with a century bit, and a two-digit year. A one-cycle `tick` pulse, produced by a prescaler outside the block, moves the chain forward by one second. Carries ripple through the whole chain within that same cycle, from seconds to minutes to hours, then to day of week and date, then month, then year and century. Month lengths and two-digit leap years are handled inside the block.

A host reaches the block through a write port and a combinational read port, both addressed by a 3-bit register index. A write to a time register loads that register directly. The control register at index 7 holds an oscillator-off bit that freezes counting. It also holds a sticky stop flag, which tells software that the time can no longer be trusted. The hours register can be in 24-hour or 12-hour form. Bit 6 selects the form and, in 12-hour form, bit 5 marks PM.

Top module: `rtc_chain`

## Requirements
- R1: The seconds (index 0) and minutes (index 1) registers count 00 to 59 in BCD. Each goes back to 00 after 59 and then carries one step into the next field.
- R2: Hours is index 2. When bit 6 is 0 it counts 00 to 23. When bit 6 is 1 it is in 12-hour form: bits 4:0 hold 01 to 12 in BCD, and bit 5 = 1 means PM. 11 AM (0x51) steps to 12 PM (0x72), 12 PM steps to 1 PM (0x61), and 12 AM (0x52) steps to 1 AM (0x41).
- R3: Day of week and date step once when the hour passes 23 to 00 in 24-hour form, or 11 PM (0x71) to 12 AM (0x52) in 12-hour form. They do not step at any other hour change.
- R4: Day of week (index 3, bits 2:0) counts 1 to 7 and then goes back to 1.
- R5: Date (index 4) goes back to 01 and carries into the month after 30 for months 04, 06, 09 and 11. For February (02) it does so after 29 in a leap year and after 28 otherwise. For all other months it does so after 31.
- R6: Month (index 5, bits 4:0) counts 01 to 12 and carries into the year when it goes back to 01. Year (index 6) counts 00 to 99 in BCD. A year is a leap year when its two-digit value is divisible by 4.
- R7: Bit 7 of index 5 is a century bit. It toggles whenever the year wraps from 99 to 00, and a host write can set it.
- R8: After reset the registers read: seconds, minutes and hours 00; day of week 01; date 01; month 01 with century 0; year 00; control 0x01 (running, stop flag set).
- R9: In the control register (index 7), bit 7 = 1 stops the oscillator and ticks are ignored. Bit 0 is the stop flag. It becomes 1 in every cycle after one in which the oscillator is stopped. Writing 0 to it clears it, and writing 1 to it leaves it unchanged. The flag also appears on `stop_flag`.
- R10: If a write to index 0 to 6 arrives in the same cycle as a tick, the written value is stored and the tick is dropped for the whole chain. A write to index 7 does not block a tick.
- R11: An illegal BCD value that was written still reaches a legal value at the next tick. A field at or above its top value wraps with a carry, and a low digit of 9 or more rolls into the tens digit.
- R12: Unused bits are not stored and read back as 0. The stored masks are: 0x7F for seconds, minutes and hours; 0x07 for day of week; 0x3F for date; 0x9F for month; 0x81 for control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset to the power-on values |
| tick | input | 1 | One-cycle pulse that advances time by one second |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register index for the read |
| rd_data | output | 8 | Contents of the indexed register, unused bits zero |
| stop_flag | output | 1 | Sticky flag showing that time may be lost |

## Verification
A wrong carry or wrong wrap value appears on the read port in the cycle after the tick that causes it. A wrong date or hour carry stays wrong for every later tick. The bench therefore compares one register against its model on every clock, rotating through all eight indexes, so any divergence is reported within eight cycles. A wrong month-length or century decision shows only at the exact boundary. Those boundaries are forced by writing values just short of each boundary and reading the result right after the tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef enum logic [2:0] {
      A_SEC   = 3'd0,
      A_MIN   = 3'd1,
      A_HOUR  = 3'd2,
      A_DOW   = 3'd3,
      A_DATE  = 3'd4,
      A_MONTH = 3'd5,
      A_YEAR  = 3'd6,
      A_CTRL  = 3'd7
   } reg_addr_e;

   // two-digit BCD year divisible by 4: (2*tens + ones) mod 4 == 0
   function automatic logic leap_year(input logic [7:0] yr);
      logic [1:0] s;
      s = {yr[4], 1'b0} + yr[1:0];
      return s == 2'b00;
   endfunction

   function automatic logic [5:0] month_last(input logic [4:0] mon, input logic leap);
      case (mon)
         5'h02:                      return leap ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
   parameter int W = 8
) (
   input  logic [W-1:0] cur,
   input  logic         en,
   input  logic [W-1:0] top,
   input  logic [W-1:0] base,
   output logic [W-1:0] nxt,
   output logic         carry
);

   generate
      if (W < 3 || W > 8) begin : g_bad_w
         $error("rtc_bcd_step: W must lie in 3..8");
      end
   endgenerate

   logic [W-1:0] inc;

   generate
      if (W > 4) begin : g_two_digit
         localparam int HW = W - 4;
         assign inc = (cur[3:0] >= 4'd9) ? {cur[W-1:4] + HW'(1), 4'h0}
                                         : cur + W'(1);
      end else begin : g_one_digit
         assign inc = cur + W'(1);
      end
   endgenerate

   assign carry = en && (cur >= top);
   assign nxt   = !en ? cur : (carry ? base : inc);

endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
   input  logic [6:0] cur,
   input  logic       en,
   output logic [6:0] nxt,
   output logic       day_carry
);

   always_comb begin
      nxt       = cur;
      day_carry = 1'b0;
      if (en) begin
         if (!cur[6]) begin
            if (cur[5:0] >= 6'h23) begin
               nxt       = 7'h00;
               day_carry = 1'b1;
            end else if (cur[3:0] >= 4'd9) begin
               nxt = {1'b0, cur[5:4] + 2'd1, 4'h0};
            end else begin
               nxt = cur + 7'd1;
            end
         end else begin
            if (cur[4:0] >= 5'h12) begin
               nxt = {1'b1, cur[5], 5'h01};
            end else if (cur[4:0] == 5'h11) begin
               nxt       = {1'b1, ~cur[5], 5'h12};
               day_carry = cur[5];
            end else if (cur[3:0] >= 4'd9) begin
               nxt = {1'b1, cur[5], 5'h10};
            end else begin
               nxt = {1'b1, cur[5], cur[4:0] + 5'd1};
            end
         end
      end
   end

endmodule

// File: rtl/rtc_chain.sv
module rtc_chain
   import rtc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              stop_flag
);

   generate
      if (DATA_W != 8 || ADDR_W != 3) begin : g_bad_geom
         $error("rtc_chain: register map needs DATA_W=8 and ADDR_W=3");
      end
   endgenerate

   logic [6:0] sec_q, min_q, hour_q;
   logic [2:0] dow_q;
   logic [5:0] date_q;
   logic [4:0] mon_q;
   logic       cent_q;
   logic [7:0] year_q;
   logic       osc_off_q, stop_q;

   logic [6:0] sec_n, min_n, hour_n;
   logic [2:0] dow_n;
   logic [5:0] date_n, date_top;
   logic [4:0] mon_n;
   logic [7:0] year_n;
   logic       sec_c, min_c, day_c, dow_c, date_c, mon_c, year_c;

   reg_addr_e wr_sel;
   logic      time_wr, ctrl_wr, advance;

   assign wr_sel   = reg_addr_e'(wr_addr);
   assign ctrl_wr  = wr_en && (wr_sel == A_CTRL);
   assign time_wr  = wr_en && (wr_sel != A_CTRL);
   assign advance  = tick && !osc_off_q && !time_wr;
   assign date_top = month_last(mon_q, leap_year(year_q));

   rtc_bcd_step #(.W(7)) u_sec (
      .cur(sec_q), .en(advance), .top(7'h59), .base(7'h00),
      .nxt(sec_n), .carry(sec_c));

   rtc_bcd_step #(.W(7)) u_min (
      .cur(min_q), .en(sec_c), .top(7'h59), .base(7'h00),
      .nxt(min_n), .carry(min_c));

   rtc_hour_step u_hour (
      .cur(hour_q), .en(min_c), .nxt(hour_n), .day_carry(day_c));

   rtc_bcd_step #(.W(3)) u_dow (
      .cur(dow_q), .en(day_c), .top(3'd7), .base(3'd1),
      .nxt(dow_n), .carry(dow_c));

   rtc_bcd_step #(.W(6)) u_date (
      .cur(date_q), .en(day_c), .top(date_top), .base(6'h01),
      .nxt(date_n), .carry(date_c));

   rtc_bcd_step #(.W(5)) u_mon (
      .cur(mon_q), .en(date_c), .top(5'h12), .base(5'h01),
      .nxt(mon_n), .carry(mon_c));

   rtc_bcd_step #(.W(8)) u_year (
      .cur(year_q), .en(mon_c), .top(8'h99), .base(8'h00),
      .nxt(year_n), .carry(year_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q     <= 7'h00;
         min_q     <= 7'h00;
         hour_q    <= 7'h00;
         dow_q     <= 3'd1;
         date_q    <= 6'h01;
         mon_q     <= 5'h01;
         cent_q    <= 1'b0;
         year_q    <= 8'h00;
         osc_off_q <= 1'b0;
         stop_q    <= 1'b1;
      end else begin
         if (time_wr) begin
            case (wr_sel)
               A_SEC:   sec_q  <= wr_data[6:0];
               A_MIN:   min_q  <= wr_data[6:0];
               A_HOUR:  hour_q <= wr_data[6:0];
               A_DOW:   dow_q  <= wr_data[2:0];
               A_DATE:  date_q <= wr_data[5:0];
               A_MONTH: begin
                  cent_q <= wr_data[7];
                  mon_q  <= wr_data[4:0];
               end
               A_YEAR:  year_q <= wr_data;
               default: ;
            endcase
         end else if (advance) begin
            sec_q  <= sec_n;
            min_q  <= min_n;
            hour_q <= hour_n;
            dow_q  <= dow_n;
            date_q <= date_n;
            mon_q  <= mon_n;
            year_q <= year_n;
            cent_q <= cent_q ^ year_c;
         end
         if (ctrl_wr) osc_off_q <= wr_data[7];
         if (osc_off_q)                    stop_q <= 1'b1;
         else if (ctrl_wr && !wr_data[0])  stop_q <= 1'b0;
      end
   end

   always_comb begin
      case (reg_addr_e'(rd_addr))
         A_SEC:   rd_data = {1'b0, sec_q};
         A_MIN:   rd_data = {1'b0, min_q};
         A_HOUR:  rd_data = {1'b0, hour_q};
         A_DOW:   rd_data = {5'b0, dow_q};
         A_DATE:  rd_data = {2'b0, date_q};
         A_MONTH: rd_data = {cent_q, 2'b0, mon_q};
         A_YEAR:  rd_data = year_q;
         default: rd_data = {osc_off_q, 6'b0, stop_q};
      endcase
   end

   assign stop_flag = stop_q;

   // R9
   osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_off_q && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(year_q)));

   // R9
   stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      osc_off_q |=> stop_flag);

   // R10
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd0) |=> (sec_q == $past(wr_data[6:0])));

   // R7
   century_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && $past(year_q) == 8'h99 && year_q == 8'h00) |-> (cent_q != $past(cent_q)));

   // R4
   dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dow_c |=> (dow_q == 3'd1));

   // R1
   sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && !$past(osc_off_q) && !$past(wr_en) && $past(sec_q) == 7'h05) |-> (sec_q == 7'h06));

endmodule

// File: tb/rtc_chain_bench.sv
module rtc_chain_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [2:0] rd_addr = 3'd0;
   logic [7:0] rd_data;
   logic       stop_flag;

   always #2 clk = ~clk;

   rtc_chain u_rtc_chain (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .stop_flag(stop_flag));

   int checks = 0;
   int fails  = 0;
   bit auto_on = 1'b1;
   logic [2:0] rot = 3'd0;

   logic [7:0] m [0:6];
   bit m_osc, m_flag;

   function automatic int b2i(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic logic [7:0] mask_of(input int a);
      case (a)
         0, 1, 2: return 8'h7F;
         3:       return 8'h07;
         4:       return 8'h3F;
         5:       return 8'h9F;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] mreg(input int a);
      if (a == 7) return {m_osc, 6'b0, m_flag};
      return m[a];
   endfunction

   function automatic string req_of(input int a);
      case (a)
         0, 1:    return "R1";
         2:       return "R2";
         3:       return "R4";
         4:       return "R5";
         5, 6:    return "R6";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
      m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00;
      m_osc = 1'b0; m_flag = 1'b1;
   endtask

   task automatic model_adv();
      int s, mi, h12, h24, mo, yr, dt, dim;
      bit md12, pm, c;
      s = b2i(m[0]) + 1;
      if (s < 60) begin m[0] = i2b(s); return; end
      m[0] = 8'h00;
      mi = b2i(m[1]) + 1;
      if (mi < 60) begin m[1] = i2b(mi); return; end
      m[1] = 8'h00;
      md12 = m[2][6];
      if (md12) begin
         h12 = b2i({3'b0, m[2][4:0]});
         pm  = m[2][5];
         h24 = (h12 % 12) + (pm ? 12 : 0);
      end else begin
         h24 = b2i(m[2]);
      end
      h24++;
      c = (h24 == 24);
      if (c) h24 = 0;
      if (md12) begin
         pm  = (h24 >= 12);
         h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
         m[2] = 8'h40 | (pm ? 8'h20 : 8'h00) | i2b(h12);
      end else begin
         m[2] = i2b(h24);
      end
      if (!c) return;
      m[3] = (m[3] >= 8'd7) ? 8'd1 : m[3] + 8'd1;
      mo = b2i({3'b0, m[5][4:0]});
      yr = b2i(m[6]);
      case (mo)
         2:             dim = (yr % 4 == 0) ? 29 : 28;
         4, 6, 9, 11:   dim = 30;
         default:       dim = 31;
      endcase
      dt = b2i(m[4]) + 1;
      if (dt <= dim) begin m[4] = i2b(dt); return; end
      m[4] = 8'h01;
      mo++;
      if (mo <= 12) begin m[5] = (m[5] & 8'h80) | i2b(mo); return; end
      m[5] = (m[5] & 8'h80) | 8'h01;
      yr++;
      if (yr < 100) begin m[6] = i2b(yr); return; end
      m[6] = 8'h00;
      m[5] = m[5] ^ 8'h80;
   endtask

   task automatic model_step(input bit t, input bit we, input logic [2:0] a, input logic [7:0] d);
      bit osc_old;
      bit tw;
      osc_old = m_osc;
      tw = we && (a != 3'd7);
      if (osc_old) m_flag = 1'b1;
      else if (we && a == 3'd7 && !d[0]) m_flag = 1'b0;
      if (we && a == 3'd7) m_osc = d[7];
      if (tw) m[a] = d & mask_of(int'(a));
      else if (t && !osc_old) model_adv();
   endtask

   task automatic cyc(input bit t, input bit we, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      rd_addr = rot;
      #1;
      if (auto_on) check(rd_data, mreg(int'(rot)), req_of(int'(rot)), "per-clock model compare");
      rot = rot + 3'd1;
      tick = t; wr_en = we; wr_addr = a; wr_data = d;
      model_step(t, we, a, d);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      cyc(1'b0, 1'b1, a, d);
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 8'h00);
   endtask

   task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string req, input string what);
      @(negedge clk);
      rd_addr = a;
      #1;
      check(rd_data, exp, req, what);
      tick = 1'b0; wr_en = 1'b0; wr_addr = 3'd0; wr_data = 8'h00;
      model_step(1'b0, 1'b0, 3'd0, 8'h00);
   endtask

   task automatic set_time(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
      wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
   endtask

   task automatic set_date(input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr);
      wr(3'd3, dw); wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog run did not complete");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8 reset values
      peek(3'd0, 8'h00, "R8", "reset seconds");
      peek(3'd1, 8'h00, "R8", "reset minutes");
      peek(3'd2, 8'h00, "R8", "reset hours");
      peek(3'd3, 8'h01, "R8", "reset day of week");
      peek(3'd4, 8'h01, "R8", "reset date");
      peek(3'd5, 8'h01, "R8", "reset month");
      peek(3'd6, 8'h00, "R8", "reset year");
      peek(3'd7, 8'h01, "R8", "reset control");
      check({7'b0, stop_flag}, 8'h01, "R8", "stop_flag pin after reset");

      // R9 clear the stop flag by writing 0
      wr(3'd7, 8'h00);
      peek(3'd7, 8'h00, "R9", "stop flag cleared by write of 0");

      // R1 R3 R4 R5 leap February, 24-hour midnight
      set_date(8'h07, 8'h28, 8'h02, 8'h24);
      set_time(8'h23, 8'h59, 8'h58);
      tk(1);
      peek(3'd0, 8'h59, "R1", "seconds step 58->59");
      tk(1);
      peek(3'd0, 8'h00, "R1", "seconds wrap");
      peek(3'd1, 8'h00, "R1", "minutes wrap");
      peek(3'd2, 8'h00, "R3", "24h midnight hour");
      peek(3'd3, 8'h01, "R4", "day of week 7->1");
      peek(3'd4, 8'h29, "R5", "leap February keeps 29");
      set_time(8'h23, 8'h59, 8'h59);
      tk(1);
      peek(3'd4, 8'h01, "R5", "leap February 29 wraps");
      peek(3'd5, 8'h03, "R5", "month after leap February");

      // R5 ordinary February
      set_date(8'h03, 8'h28, 8'h02, 8'h23);
      set_time(8'h23, 8'h59, 8'h59);
      tk(1);
      peek(3'd4, 8'h01, "R5", "ordinary February 28 wraps");
      peek(3'd5, 8'h03, "R5", "month after ordinary February");
      peek(3'd3, 8'h04, "R4", "day of week step");

      // R5 30-day month, and 31 not wrapping in a 31-day month
      set_date(8'h02, 8'h30, 8'h04, 8'h10);
      set_time(8'h23, 8'h59, 8'h59);
      tk(1);
      peek(3'd4, 8'h01, "R5", "April 30 wraps");
      peek(3'd5, 8'h05, "R5", "April to May");
      set_date(8'h02, 8'h30, 8'h05, 8'h10);
      set_time(8'h23, 8'h59, 8'h59);
      tk(1);
      peek(3'd4, 8'h31, "R5", "May 30 to 31");

      // R6 year carry
      set_date(8'h01, 8'h31, 8'h12, 8'h23);
      set_time(8'h23, 8'h59, 8'h59);
      tk(1);
      peek(3'd5, 8'h01, "R6", "December to January");
      peek(3'd6, 8'h24, "R6", "year step");

      // R7 century toggle both ways
      set_date(8'h01, 8'h31, 8'h12, 8'h99);
      set_time(8'h23, 8'h59, 8'h59);
      tk(1);
      peek(3'd5, 8'h81, "R7", "century set on year wrap");
      peek(3'd6, 8'h00, "R6", "year 99 wraps to 00");
      set_date(8'h01, 8'h31, 8'h92, 8'h99);
      set_time(8'h23, 8'h59, 8'h59);
      tk(1);
      peek(3'd5, 8'h01, "R7", "century cleared on next year wrap");

      // R2 R3 12-hour form
      set_date(8'h05, 8'h10, 8'h06, 8'h30);
      set_time(8'h71, 8'h59, 8'h59);
      tk(1);
      peek(3'd2, 8'h52, "R2", "11 PM to 12 AM");
      peek(3'd4, 8'h11, "R3", "date steps at 12h midnight");
      set_time(8'h52, 8'h59, 8'h59);
      tk(1);
      peek(3'd2, 8'h41, "R2", "12 AM to 1 AM");
      set_time(8'h51, 8'h59, 8'h59);
      tk(1);
      peek(3'd2, 8'h72, "R2", "11 AM to 12 PM");
      peek(3'd4, 8'h11, "R3", "no date step at noon");
      set_time(8'h72, 8'h59, 8'h59);
      tk(1);
      peek(3'd2, 8'h61, "R2", "12 PM to 1 PM");

      // R1 minute carry without hour carry
      set_time(8'h05, 8'h12, 8'h59);
      tk(1);
      peek(3'd1, 8'h13, "R1", "minutes step on second wrap");
      peek(3'd2, 8'h05, "R1", "hour unchanged");

      // R10 write priority over a tick
      set_time(8'h05, 8'h20, 8'h10);
      cyc(1'b1, 1'b1, 3'd0, 8'h33);
      peek(3'd0, 8'h33, "R10", "write wins over tick");
      cyc(1'b1, 1'b1, 3'd1, 8'h21);
      peek(3'd0, 8'h33, "R10", "tick dropped during minute write");
      cyc(1'b1, 1'b1, 3'd7, 8'h00);
      peek(3'd0, 8'h34, "R10", "control write does not block tick");

      // R9 oscillator off
      wr(3'd7, 8'h80);
      tk(5);
      peek(3'd0, 8'h34, "R9", "ticks ignored while stopped");
      peek(3'd7, 8'h81, "R9", "stop flag set while stopped");
      check({7'b0, stop_flag}, 8'h01, "R9", "stop_flag pin while stopped");
      wr(3'd7, 8'h01);
      wr(3'd7, 8'h01);
      peek(3'd7, 8'h01, "R9", "writing 1 leaves flag set");
      wr(3'd7, 8'h00);
      peek(3'd7, 8'h00, "R9", "flag cleared once running");
      tk(1);
      peek(3'd0, 8'h35, "R9", "counting resumes");

      // R12 unused bits, R11 illegal values
      auto_on = 1'b0;
      wr(3'd0, 8'hFF);
      peek(3'd0, 8'h7F, "R12", "seconds mask");
      wr(3'd3, 8'hFF);
      peek(3'd3, 8'h07, "R12", "day of week mask");
      wr(3'd4, 8'hFF);
      peek(3'd4, 8'h3F, "R12", "date mask");
      wr(3'd5, 8'h7F);
      peek(3'd5, 8'h1F, "R12", "month mask");
      wr(3'd7, 8'h7E);
      peek(3'd7, 8'h00, "R12", "control mask");
      set_date(8'h02, 8'h10, 8'h03, 8'h40);
      set_time(8'h08, 8'h00, 8'h7F);
      tk(1);
      peek(3'd0, 8'h00, "R11", "illegal seconds wrap");
      peek(3'd1, 8'h01, "R11", "illegal seconds carry");
      wr(3'd0, 8'h2B);
      tk(1);
      peek(3'd0, 8'h30, "R11", "illegal low digit rolls");
      set_time(8'h3F, 8'h59, 8'h59);
      tk(1);
      peek(3'd2, 8'h00, "R11", "illegal hour wraps");
      peek(3'd4, 8'h11, "R11", "illegal hour carries to date");

      // long compared runs
      set_date(8'h06, 8'h28, 8'h02, 8'h99);
      set_time(8'h71, 8'h59, 8'h50);
      auto_on = 1'b1;
      for (int i = 0; i < 900; i++) cyc(i % 3 != 0, 1'b0, 3'd0, 8'h00);
      set_date(8'h07, 8'h31, 8'h12, 8'h99);
      set_time(8'h23, 8'h58, 8'h30);
      for (int i = 0; i < 600; i++) cyc(i % 4 != 1, 1'b0, 3'd0, 8'h00);
      tk(40);

      finish_run();
   end

endmodule